// File: doc/BRIEF.md
# BCD Calendar Counter With Register Access

The block keeps the time of day and a calendar: seconds, minutes, hours, day of week, day of month, month and a three-digit year. It advances one second each time it has seen a set number of base-clock enables, 32768 by default, from a slow reference. Each field is held in binary inside the block. Fields are converted to BCD when software reads them and from BCD when software writes them.

A simple bus port reaches one control word and seven time words at fixed offsets. Reads return data on the cycle after the request. Bit 0 of the control word starts and stops the clock. While the clock is stopped, writes to time words have no effect. The block drives a one-cycle strobe once per second to downstream alarm logic. The strobe is high during the first cycle in which the new time is visible.

Top module: `bcdcal_top`

## Requirements
- R1: After a synchronous reset the control word reads 0, the clock is stopped, `sec_strobe` is low and the time reads 00:00:00, day of week 0, day 0x01, month 0x01, year 0x000.
- R2: While the clock runs, every DIV_COUNT-th cycle with `base_en` high advances the time by one second. `sec_strobe` is high for exactly the one cycle that follows that advance. Cycles with `base_en` low do not count. While the clock is stopped the divider holds its count and no strobe occurs.
- R3: A write that sets control bit 0 while it is 0 restarts the divider, so the first second after the restart needs DIV_COUNT fresh enables.
- R4: Word offsets are control 0x40 (bit 0 = clock run), seconds 0x70, minutes 0x74, hours 0x78, day of month 0x7C, day of week 0x80, month 0x84 and year 0x88. Time fields read as two BCD digits in bits 7:0. Any other offset reads 0. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds until the next read.
- R5: A write to any time word while control bit 0 is clear leaves the time unchanged.
- R6: The year word carries the tens and units digits in bits 7:0 and the hundreds digit in bits 11:8. The stored year counts from 1900 and wraps from 999 to 0.
- R7: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. Each wrap advances the next field in the same step.
- R8: Day of week advances when the hour wraps and goes from 6 back to 0.
- R9: After the last day of the month, the day becomes 0x01 and the month advances. April, June, September and November have 30 days. After month 0x12 the month becomes 0x01 and the year increments.
- R10: February has 29 days when (stored year + 1900) is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28 days.
- R11: A read in the same cycle as a one-second advance returns the value from before the advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_en | input | 1 | One-cycle enable from the slow reference, counted by the divider |
| bus_wr | input | 1 | Write request for the word at `bus_addr` |
| bus_rd | input | 1 | Read request for the word at `bus_addr` |
| bus_addr | input | ADDR_W (8) | Byte offset of the word |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, loaded one edge after the request |
| sec_strobe | output | 1 | One-cycle pulse after each second advance |

## Verification
Two functions can fall in the same cycle: a bus read of the seconds word and the one-second advance. The bench sends DIV_COUNT-1 enables and then raises the final enable in the same cycle as a read of the seconds word. The scoreboard expects the old value from that read, and the new value from a read one cycle later. The restart-on-enable rule is provoked by a half-counted second followed by stop and start. After that, one enable short of a full second must give no strobe.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int WORD_W = 12;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int WDAY_W = 3;
    localparam int MDAY_W = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 10;

    localparam logic [7:0] OFS_CTRL = 8'h40;
    localparam logic [7:0] OFS_SEC  = 8'h70;
    localparam logic [7:0] OFS_MIN  = 8'h74;
    localparam logic [7:0] OFS_HOUR = 8'h78;
    localparam logic [7:0] OFS_MDAY = 8'h7C;
    localparam logic [7:0] OFS_WDAY = 8'h80;
    localparam logic [7:0] OFS_MON  = 8'h84;
    localparam logic [7:0] OFS_YEAR = 8'h88;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [MDAY_W-1:0] mday;
        logic [WDAY_W-1:0] wday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    typedef enum logic [2:0] {
        F_NONE, F_SEC, F_MIN, F_HOUR, F_MDAY, F_WDAY, F_MON, F_YEAR
    } field_e;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        int t;
        t = int'(v) % 100;
        return {4'(t / 10), 4'(t % 10)};
    endfunction

    function automatic logic [YEAR_W-1:0] year_from_bcd(input logic [11:0] w);
        int v;
        v = int'(bcd_to_bin(w[7:0])) + 100 * int'(w[11:8]);
        return YEAR_W'(v);
    endfunction

    function automatic logic [11:0] year_to_bcd(input logic [YEAR_W-1:0] y);
        int yy;
        yy = int'(y);
        return {4'((yy / 100) % 10), bin_to_bcd(7'(yy % 100))};
    endfunction

    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        int full;
        full = int'(y) + 1900;
        return (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    endfunction

    function automatic logic [MDAY_W-1:0] days_in_month(input logic [MON_W-1:0] m,
                                                        input logic [YEAR_W-1:0] y);
        case (m)
            4'd2:                      return is_leap(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/bcdcal_divider.sv
module bcdcal_divider #(
    parameter int DIV_COUNT = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic base_en,
    output logic tick,
    output logic strobe
);
    localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

    logic [CW-1:0] cnt;

    assign tick = run && base_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= tick;
            if (restart)
                cnt <= '0;
            else if (run && base_en)
                cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R3: a start request empties the divider
    p_restart_clears_r3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R2: a stopped clock holds the divider count
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt));

endmodule

// File: rtl/bcdcal_counter.sv
module bcdcal_counter
    import bcdcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  field_e            wr_field,
    input  logic [YEAR_W-1:0] wr_bin,
    output cal_t              now
);
    cal_t nxt;
    logic [MDAY_W-1:0] dim;

    assign dim = days_in_month(now.mon, now.year);

    always_comb begin
        nxt = now;
        if (tick) begin
            if (now.sec >= SEC_W'(59)) begin
                nxt.sec = '0;
                if (now.min >= MIN_W'(59)) begin
                    nxt.min = '0;
                    if (now.hour >= HOUR_W'(23)) begin
                        nxt.hour = '0;
                        nxt.wday = (now.wday >= WDAY_W'(6)) ? '0 : now.wday + 1'b1;
                        if (now.mday >= dim) begin
                            nxt.mday = MDAY_W'(1);
                            if (now.mon >= MON_W'(12)) begin
                                nxt.mon  = MON_W'(1);
                                nxt.year = (now.year >= YEAR_W'(999)) ? '0 : now.year + 1'b1;
                            end else begin
                                nxt.mon = now.mon + 1'b1;
                            end
                        end else begin
                            nxt.mday = now.mday + 1'b1;
                        end
                    end else begin
                        nxt.hour = now.hour + 1'b1;
                    end
                end else begin
                    nxt.min = now.min + 1'b1;
                end
            end else begin
                nxt.sec = now.sec + 1'b1;
            end
        end
        case (wr_field)
            F_SEC:   nxt.sec  = SEC_W'(wr_bin);
            F_MIN:   nxt.min  = MIN_W'(wr_bin);
            F_HOUR:  nxt.hour = HOUR_W'(wr_bin);
            F_MDAY:  nxt.mday = MDAY_W'(wr_bin);
            F_WDAY:  nxt.wday = WDAY_W'(wr_bin);
            F_MON:   nxt.mon  = MON_W'(wr_bin);
            F_YEAR:  nxt.year = wr_bin;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now      <= '0;
            now.mday <= MDAY_W'(1);
            now.mon  <= MON_W'(1);
        end else begin
            now <= nxt;
        end
    end

    // R7: seconds wrap to zero on an undisturbed advance
    p_sec_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_field == F_NONE && now.sec == SEC_W'(59)) |=> (now.sec == '0));

    // R8: day of week wraps from 6 to 0 at midnight
    p_wday_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_field == F_NONE && now.sec == SEC_W'(59) && now.min == MIN_W'(59) &&
         now.hour == HOUR_W'(23) && now.wday == WDAY_W'(6)) |=> (now.wday == '0));

    // R10: a year 2000 February reaches day 29
    p_leap_2000_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_field == F_NONE && now.sec == SEC_W'(59) && now.min == MIN_W'(59) &&
         now.hour == HOUR_W'(23) && now.mon == MON_W'(2) && now.mday == MDAY_W'(28) &&
         now.year == YEAR_W'(100)) |=> (now.mday == MDAY_W'(29)));

endmodule

// File: rtl/bcdcal_regs.sv
module bcdcal_regs
    import bcdcal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  cal_t              now,
    output logic              run,
    output logic              restart,
    output field_e            wr_field,
    output logic [YEAR_W-1:0] wr_bin,
    output logic [WORD_W-1:0] rdata
);
    field_e sel;
    logic is_ctrl;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        sel     = F_NONE;
        is_ctrl = 1'b0;
        case (addr)
            ADDR_W'(OFS_CTRL): is_ctrl = 1'b1;
            ADDR_W'(OFS_SEC):  sel = F_SEC;
            ADDR_W'(OFS_MIN):  sel = F_MIN;
            ADDR_W'(OFS_HOUR): sel = F_HOUR;
            ADDR_W'(OFS_MDAY): sel = F_MDAY;
            ADDR_W'(OFS_WDAY): sel = F_WDAY;
            ADDR_W'(OFS_MON):  sel = F_MON;
            ADDR_W'(OFS_YEAR): sel = F_YEAR;
            default: ;
        endcase
    end

    assign restart  = wr_en && is_ctrl && wdata[0] && !run;
    assign wr_field = (wr_en && run) ? sel : F_NONE;
    assign wr_bin   = (sel == F_YEAR) ? year_from_bcd(wdata) : YEAR_W'(bcd_to_bin(wdata[7:0]));

    always_comb begin
        rd_word = '0;
        case (sel)
            F_SEC:   rd_word[7:0] = bin_to_bcd(7'(now.sec));
            F_MIN:   rd_word[7:0] = bin_to_bcd(7'(now.min));
            F_HOUR:  rd_word[7:0] = bin_to_bcd(7'(now.hour));
            F_MDAY:  rd_word[7:0] = bin_to_bcd(7'(now.mday));
            F_WDAY:  rd_word[7:0] = bin_to_bcd(7'(now.wday));
            F_MON:   rd_word[7:0] = bin_to_bcd(7'(now.mon));
            F_YEAR:  rd_word      = year_to_bcd(now.year);
            default: rd_word[0]   = is_ctrl && run;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            rdata <= '0;
        end else begin
            if (wr_en && is_ctrl)
                run <= wdata[0];
            if (rd_en)
                rdata <= rd_word;
        end
    end

    // R5: no time field is touched while the clock is stopped
    p_locked_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !run) |-> (wr_field == F_NONE));

endmodule

// File: rtl/bcdcal_top.sv
module bcdcal_top
    import bcdcal_pkg::*;
#(
    parameter int DIV_COUNT = 32768,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sec_strobe
);
    logic              run;
    logic              restart;
    logic              tick;
    field_e            wr_field;
    logic [YEAR_W-1:0] wr_bin;
    cal_t              now;

    bcdcal_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .base_en (base_en),
        .tick    (tick),
        .strobe  (sec_strobe)
    );

    bcdcal_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .now      (now),
        .run      (run),
        .restart  (restart),
        .wr_field (wr_field),
        .wr_bin   (wr_bin),
        .rdata    (bus_rdata)
    );

    bcdcal_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_field (wr_field),
        .wr_bin   (wr_bin),
        .now      (now)
    );

endmodule

// File: tb/bcdcal_top_test.sv
`timescale 1ns/1ps
module bcdcal_top_test;
    localparam int DIV = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        base_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic        sec_strobe;

    bcdcal_top #(.DIV_COUNT(DIV)) uut (
        .clk(clk), .rst(rst), .base_en(base_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_strobe(sec_strobe)
    );

    int checks = 0;
    int errors = 0;
    int strobe_cnt = 0;
    logic rd_pend = 1'b0;
    logic [11:0] exp_q[$];
    string tag_q[$];

    always @(posedge clk) rd_pend <= bus_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            logic [11:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: actual 0x%03h expected 0x%03h", t, bus_rdata, e);
            end
        end
        if (sec_strobe === 1'b1) strobe_cnt++;
    end

    task automatic chk(input int act, input int exp, input string t);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [11:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [11:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            base_en = 1'b1;
        end
        @(negedge clk);
        base_en = 1'b0;
    endtask

    task automatic set_time(input logic [11:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(8'h88, y);
        wr(8'h84, {4'h0, mo});
        wr(8'h7C, {4'h0, d});
        wr(8'h80, {4'h0, wd});
        wr(8'h78, {4'h0, h});
        wr(8'h74, {4'h0, mi});
        wr(8'h70, {4'h0, s});
    endtask

    task automatic rd_date(input logic [11:0] y, input logic [7:0] mo, input logic [7:0] d,
                           input string t);
        rd(8'h88, y, {t, " year"});
        rd(8'h84, {4'h0, mo}, {t, " month"});
        rd(8'h7C, {4'h0, d}, {t, " day"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(int'(sec_strobe), 0, "R1 strobe after reset");
        rd(8'h40, 12'h000, "R1 control reset");
        rd(8'h70, 12'h000, "R1 seconds reset");
        rd(8'h74, 12'h000, "R1 minutes reset");
        rd(8'h78, 12'h000, "R1 hours reset");
        rd(8'h80, 12'h000, "R1 weekday reset");
        rd_date(12'h000, 8'h01, 8'h01, "R1 reset");
        rd(8'h44, 12'h000, "R4 unmapped offset");

        // R5: writes while stopped
        wr(8'h70, 12'h030);
        wr(8'h88, 12'h555);
        rd(8'h70, 12'h000, "R5 seconds write while stopped");
        rd(8'h88, 12'h000, "R5 year write while stopped");

        // start and load 2099-12-31 23:59:58, weekday 6
        wr(8'h40, 12'h001);
        rd(8'h40, 12'h001, "R4 control readback");
        set_time(12'h199, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h58);
        rd(8'h88, 12'h199, "R6 year split readback");
        rd(8'h70, 12'h058, "R4 seconds readback");

        settle(); s0 = strobe_cnt;
        pulse(DIV);
        settle();
        chk(strobe_cnt - s0, 1, "R2 one strobe per DIV enables");
        rd(8'h70, 12'h059, "R2 seconds advanced");
        rd(8'h74, 12'h059, "R7 minutes unchanged");

        pulse(DIV);
        rd(8'h70, 12'h000, "R7 seconds wrap");
        rd(8'h74, 12'h000, "R7 minutes wrap");
        rd(8'h78, 12'h000, "R7 hours wrap");
        rd(8'h80, 12'h000, "R8 weekday 6 to 0");
        rd_date(12'h200, 8'h01, 8'h01, "R9 new year");

        // R10: 2000 leap
        set_time(12'h100, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(DIV);
        rd_date(12'h100, 8'h02, 8'h29, "R10 year 2000 Feb 29");
        rd(8'h80, 12'h004, "R8 weekday advance");
        wr(8'h78, 12'h023); wr(8'h74, 12'h059); wr(8'h70, 12'h059);
        pulse(DIV);
        rd_date(12'h100, 8'h03, 8'h01, "R10 year 2000 after Feb 29");

        // R10: 1900 not leap
        set_time(12'h000, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(DIV);
        rd_date(12'h000, 8'h03, 8'h01, "R10 year 1900 no Feb 29");

        // R10: 2100 not leap
        set_time(12'h200, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(DIV);
        rd_date(12'h200, 8'h03, 8'h01, "R10 year 2100 no Feb 29");

        // R10: 1924 leap
        set_time(12'h024, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(DIV);
        rd_date(12'h024, 8'h02, 8'h29, "R10 year 1924 Feb 29");

        // R9: 30-day month
        set_time(12'h024, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(DIV);
        rd_date(12'h024, 8'h05, 8'h01, "R9 April 30 rollover");

        // R6: year 999 wraps to 0
        set_time(12'h999, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
        pulse(DIV);
        rd_date(12'h000, 8'h01, 8'h01, "R6 year wrap");

        // R11: read collides with advance (seconds now 00)
        pulse(DIV - 1);
        @(negedge clk);
        base_en = 1'b1; bus_rd = 1'b1; bus_addr = 8'h70;
        exp_q.push_back(12'h000); tag_q.push_back("R11 read in advance cycle");
        @(negedge clk);
        base_en = 1'b0; bus_rd = 1'b0;
        rd(8'h70, 12'h001, "R11 read after advance");

        // R2: stopped clock
        wr(8'h40, 12'h000);
        settle(); s0 = strobe_cnt;
        pulse(2 * DIV);
        settle();
        chk(strobe_cnt - s0, 0, "R2 no strobe while stopped");
        rd(8'h70, 12'h001, "R2 seconds held while stopped");

        // R3: restart after half a second
        wr(8'h40, 12'h001);
        pulse(DIV / 2);
        wr(8'h40, 12'h000);
        wr(8'h40, 12'h001);
        settle(); s0 = strobe_cnt;
        pulse(DIV - 1);
        settle();
        chk(strobe_cnt - s0, 0, "R3 no strobe before full count after restart");
        rd(8'h70, 12'h001, "R3 seconds before full count");
        pulse(1);
        settle();
        chk(strobe_cnt - s0, 1, "R3 strobe at full count after restart");
        rd(8'h70, 12'h002, "R3 seconds after full count");

        // R2: gapped enables
        s0 = strobe_cnt;
        for (int i = 0; i < 4 * DIV; i++) begin
            @(negedge clk);
            base_en = (i % 2 == 0);
        end
        @(negedge clk);
        base_en = 1'b0;
        settle();
        chk(strobe_cnt - s0, 2, "R2 gapped enables");
        rd(8'h70, 12'h004, "R2 seconds after gapped enables");

        settle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule